// File: doc/BRIEF.md
# Chainable Multi-Channel Periodic Tick Timer

This block is a memory-mapped timer with a parameterised number of independent down-counting channels (four by default, 32 bits each). Software reaches it over a plain register bus made of an address, write data, a write strobe, a read strobe and read data. Each channel has a reload value, a readable live count, a control word and a sticky expiry flag. A channel counts down once per clock. When it passes through zero it reloads from its reload value, raises its flag and keeps running. The channel never stops by itself.

A module-level register can halt every channel at once. Any channel except the first can be set to step only when the channel just below it expires. Two neighbours then form one wide counter, such as a 64-bit count built from channels 0 and 1. One interrupt line is the OR over all channels of each flag masked by that channel's interrupt enable.

Top module: `tick_timer`

## Requirements
- R1: After reset every channel register reads zero, the module control word at offset 0x00 reads 0x2 (halt bit 1 set), and `irq_out` is low.
- R2: With reload value L and the channel enabled, the flag (bit 0 of the flag word at channel offset +0x0C) rises L+1 clock edges after the edge that enabled the channel.
- R3: The count word (+0x04) reads the live count. On the edge that turns the enable on (control word +0x08, bit 0, from 0 to 1), the count takes the reload value (+0x00). Each later edge lowers it by one.
- R4: Writing the reload value while a channel runs leaves the count in progress unchanged. The new value is taken only at the next reload.
- R5: Writing 0 to the control word stops the channel, and its count holds. Setting bit 0 again restarts the count at once from the current reload value.
- R6: While bit 1 of the module control word is 1, no channel counts and counts hold. Counting resumes on the edge after the write that clears the bit.
- R7: Writing 1 to flag bit 0 clears the flag, and writing 0 leaves it unchanged. If a clear write and an expiry fall on the same edge, the flag ends set.
- R8: `irq_out` is high exactly when some channel has both its flag set and control bit 1 (interrupt enable) set.
- R9: A channel n>0 whose control bit 2 (chain) is set lowers its count only on edges where channel n-1 expires.
- R10: Reads of unmapped offsets, such as 0x04 or a channel slot past the last channel, return zero. `bus_rdata` is zero while `bus_re` is low.
- R11: On expiry the count reloads and counting continues, with no one-shot stop. Channel n sits at 0x100 + 0x10*n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, takes effect on the rising edge |
| bus_re | input | 1 | Read strobe, selects combinational read data |
| bus_rdata | output | 32 | Read data, zero when not reading or unmapped |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
A write takes effect on the edge it is presented to, so a count or flag changed by a write is sampled 1 ns after that edge. Read data is combinational and is sampled in the same time step, with no edge spent. Every count check is derived by counting edges from the enabling write: the count equals L-k after k further edges, and the flag rises on edge L+1. Every write task returns 1 ns after its edge, and later checks count edges from there. The same-edge clear-versus-expiry case is timed so the clearing write's edge is exactly the expiry edge.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   // register offsets inside one channel slot
   localparam logic [3:0] OFS_RELOAD = 4'h0;
   localparam logic [3:0] OFS_COUNT  = 4'h4;
   localparam logic [3:0] OFS_CTRL   = 4'h8;
   localparam logic [3:0] OFS_FLAG   = 4'hC;
   // control word bit positions
   localparam int CTL_RUN   = 0;
   localparam int CTL_IE    = 1;
   localparam int CTL_CHAIN = 2;
   localparam int CTL_W     = 3;
   // module control word
   localparam int MOD_HALT  = 1;

   typedef struct packed {
      logic chain;
      logic ie;
      logic run;
   } chan_ctl_t;
endpackage

// File: rtl/tick_timer_decode.sv
module tick_timer_decode
   import tick_timer_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_CH    = 4,
   parameter int CH_BASE   = 'h100,
   parameter int CH_STRIDE = 'h10
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   output logic              mod_wr,
   output logic              mod_sel,
   output logic [NUM_CH-1:0] rld_wr,
   output logic [NUM_CH-1:0] ctl_wr,
   output logic [NUM_CH-1:0] flg_wr,
   output logic [NUM_CH-1:0] slot_hit,
   output logic [3:0]        reg_ofs
);
   localparam int SPAN = CH_BASE + NUM_CH * CH_STRIDE;

   generate
      if (CH_STRIDE < 16) begin : g_bad_stride
         $error("CH_STRIDE must hold four registers");
      end
      if (SPAN > (1 << ADDR_W)) begin : g_bad_span
         $error("channel slots exceed address space");
      end
   endgenerate

   assign reg_ofs = addr[3:0];
   assign mod_sel = (addr == '0);
   assign mod_wr  = we && mod_sel;

   always_comb begin
      rld_wr   = '0;
      ctl_wr   = '0;
      flg_wr   = '0;
      slot_hit = '0;
      for (int n = 0; n < NUM_CH; n++) begin
         if (int'(addr) >= CH_BASE + n * CH_STRIDE &&
             int'(addr) <  CH_BASE + n * CH_STRIDE + 16) begin
            slot_hit[n] = 1'b1;
            rld_wr[n]   = we && (addr[3:0] == OFS_RELOAD);
            ctl_wr[n]   = we && (addr[3:0] == OFS_CTRL);
            flg_wr[n]   = we && (addr[3:0] == OFS_FLAG);
         end
      end
   end
endmodule

// File: rtl/tick_timer_channel.sv
module tick_timer_channel
   import tick_timer_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter bit HAS_PRED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt,
   input  logic             rld_wr,
   input  logic             ctl_wr,
   input  logic             flg_wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             pred_expire,
   output logic [CNT_W-1:0] reload_o,
   output logic [CNT_W-1:0] count_o,
   output chan_ctl_t        ctl_o,
   output logic             flag_o,
   output logic             expire_o
);
   logic [CNT_W-1:0] reload_q, count_q;
   chan_ctl_t        ctl_q;
   logic             flag_q;
   logic             step, active, start;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("CNT_W too small");
      end
      if (HAS_PRED) begin : g_chained
         assign step = ctl_q.chain ? pred_expire : 1'b1;
      end else begin : g_free
         assign step = 1'b1;
      end
   endgenerate

   assign active   = ctl_q.run && !halt;
   assign start    = ctl_wr && wdata[CTL_RUN] && !ctl_q.run;
   assign expire_o = active && step && (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         count_q  <= '0;
         ctl_q    <= '0;
         flag_q   <= 1'b0;
      end else begin
         if (rld_wr) reload_q <= wdata;
         if (ctl_wr) ctl_q <= chan_ctl_t'(wdata[CTL_W-1:0]);
         if (start) count_q <= reload_q;
         else if (active && step) begin
            if (count_q == '0) count_q <= reload_q;
            else               count_q <= count_q - 1'b1;
         end
         if (expire_o)                    flag_q <= 1'b1;
         else if (flg_wr && wdata[0])     flag_q <= 1'b0;
      end
   end

   assign reload_o = reload_q;
   assign count_o  = count_q;
   assign ctl_o    = ctl_q;
   assign flag_o   = flag_q;

   // R6 R5
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !start) |=> $stable(count_q));
   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> flag_q);
   // R11
   reload_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !rld_wr) |=> (count_q == reload_q));
   // R9
   chain_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_PRED && ctl_q.chain && !pred_expire && !start) |=> $stable(count_q));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter int NUM_CH    = 4,
   parameter int CH_BASE   = 'h100,
   parameter int CH_STRIDE = 'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);
   generate
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must not exceed DATA_W");
      end
      if (NUM_CH < 1) begin : g_bad_num
         $error("NUM_CH must be at least 1");
      end
   endgenerate

   logic              halt_q;
   logic              mod_wr, mod_sel;
   logic [NUM_CH-1:0] rld_wr, ctl_wr, flg_wr, slot_hit;
   logic [3:0]        reg_ofs;
   logic [CNT_W-1:0]  reload_v [NUM_CH];
   logic [CNT_W-1:0]  count_v  [NUM_CH];
   chan_ctl_t         ctl_v    [NUM_CH];
   logic [NUM_CH-1:0] flag_v, expire_v, ie_v;

   tick_timer_decode #(
      .ADDR_W(ADDR_W), .NUM_CH(NUM_CH),
      .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
   ) u_decode (
      .addr(bus_addr), .we(bus_we), .mod_wr(mod_wr), .mod_sel(mod_sel),
      .rld_wr(rld_wr), .ctl_wr(ctl_wr), .flg_wr(flg_wr),
      .slot_hit(slot_hit), .reg_ofs(reg_ofs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      halt_q <= 1'b1;
      else if (mod_wr) halt_q <= bus_wdata[MOD_HALT];
   end

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
         logic pred;
         if (n == 0) begin : g_head
            assign pred = 1'b0;
         end else begin : g_link
            assign pred = expire_v[n-1];
         end
         tick_timer_channel #(
            .CNT_W(CNT_W), .HAS_PRED(n != 0)
         ) u_chan (
            .clk(clk), .rst_n(rst_n), .halt(halt_q),
            .rld_wr(rld_wr[n]), .ctl_wr(ctl_wr[n]), .flg_wr(flg_wr[n]),
            .wdata(bus_wdata[CNT_W-1:0]), .pred_expire(pred),
            .reload_o(reload_v[n]), .count_o(count_v[n]), .ctl_o(ctl_v[n]),
            .flag_o(flag_v[n]), .expire_o(expire_v[n])
         );
         assign ie_v[n] = ctl_v[n].ie;
      end
   endgenerate

   assign irq_out = |(flag_v & ie_v);

   always_comb begin
      bus_rdata = '0;
      if (bus_re) begin
         if (mod_sel) bus_rdata[MOD_HALT] = halt_q;
         for (int n = 0; n < NUM_CH; n++) begin
            if (slot_hit[n]) begin
               unique case (reg_ofs)
                  OFS_RELOAD: bus_rdata[CNT_W-1:0] = reload_v[n];
                  OFS_COUNT:  bus_rdata[CNT_W-1:0] = count_v[n];
                  OFS_CTRL:   bus_rdata[CTL_W-1:0] = ctl_v[n];
                  OFS_FLAG:   bus_rdata[0]         = flag_v[n];
                  default:    ;
               endcase
            end
         end
      end
   end

   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_v & ie_v) == '0) |-> !irq_out);
   // R10
   idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |-> (bus_rdata == '0));
   // R6
   halt_no_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> (expire_v == '0));
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq_out;
   int          checks = 0;
   int          errors = 0;

   always #10 clk = ~clk;

   tick_timer u_tick_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   function automatic logic [11:0] ra(input int ch, input int ofs);
      return 12'(32'h100 + 32'h10 * ch + ofs);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a; bus_re = 1'b1; #1;
      d = bus_rdata; bus_re = 1'b0;
   endtask

   task automatic edges(input int k);
      repeat (k) @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(12'h000, d);       check("R1 module control", d, 32'h2);
      rd(ra(0, 0), d);      check("R1 reload", d, 0);
      rd(ra(2, 8), d);      check("R1 control", d, 0);
      rd(ra(3, 4), d);      check("R1 count", d, 0);
      check("R1 irq", irq_out, 0);
   endtask

   task automatic t_period;
      logic [31:0] d;
      wr(12'h000, 0);
      wr(ra(0, 0), 5);
      wr(ra(0, 8), 1);
      rd(ra(0, 4), d);      check("R3 count at enable", d, 5);
      edges(3);
      rd(ra(0, 4), d);      check("R3 live count", d, 2);
      edges(2);
      rd(ra(0, 12), d);     check("R2 flag before L+1", d, 0);
      edges(1);
      rd(ra(0, 12), d);     check("R2 flag at L+1", d, 1);
      rd(ra(0, 4), d);      check("R11 reload after expiry", d, 5);
      wr(ra(0, 12), 0);
      rd(ra(0, 12), d);     check("R7 write 0 keeps flag", d, 1);
      check("R8 irq masked", irq_out, 0);
      wr(ra(0, 12), 1);
      rd(ra(0, 12), d);     check("R7 write 1 clears", d, 0);
      edges(3);
      wr(ra(0, 12), 1);
      rd(ra(0, 12), d);     check("R7 set wins", d, 1);
      wr(ra(0, 8), 3);
      check("R8 irq enabled", irq_out, 1);
      wr(ra(0, 8), 0);
      check("R8 irq masked again", irq_out, 0);
   endtask

   task automatic t_reload_write;
      logic [31:0] d;
      wr(ra(1, 0), 10);
      wr(ra(1, 8), 1);
      wr(ra(1, 0), 3);
      rd(ra(1, 4), d);      check("R4 count undisturbed", d, 9);
      edges(10);
      rd(ra(1, 4), d);      check("R4 new value at reload", d, 3);
      rd(ra(1, 12), d);     check("R4 flag at reload", d, 1);
   endtask

   task automatic t_restart;
      logic [31:0] d, held;
      wr(ra(1, 0), 7);
      wr(ra(1, 8), 0);
      rd(ra(1, 4), held);
      edges(3);
      rd(ra(1, 4), d);      check("R5 stopped count holds", d, held);
      wr(ra(1, 8), 1);
      rd(ra(1, 4), d);      check("R5 restart loads reload", d, 7);
   endtask

   task automatic t_halt;
      logic [31:0] d;
      wr(12'h000, 32'h2);
      rd(ra(1, 4), d);      check("R6 last step before halt", d, 6);
      edges(4);
      rd(ra(1, 4), d);      check("R6 halted holds", d, 6);
      wr(12'h000, 0);
      rd(ra(1, 4), d);      check("R6 no step on clear edge", d, 6);
      edges(1);
      rd(ra(1, 4), d);      check("R6 resumes", d, 5);
      wr(ra(1, 8), 0);
   endtask

   task automatic t_chain;
      logic [31:0] d;
      wr(ra(2, 0), 2);
      wr(ra(3, 0), 4);
      wr(ra(3, 8), 5);
      wr(ra(2, 8), 1);
      edges(2);
      rd(ra(3, 4), d);      check("R9 waits for predecessor", d, 4);
      edges(1);
      rd(ra(3, 4), d);      check("R9 steps on expiry", d, 3);
      edges(2);
      rd(ra(3, 4), d);      check("R9 still waiting", d, 3);
      edges(1);
      rd(ra(3, 4), d);      check("R9 second step", d, 2);
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      rd(12'h004, d);       check("R10 gap offset", d, 0);
      rd(ra(4, 0), d);      check("R10 past last channel", d, 0);
      bus_addr = ra(3, 0); bus_re = 1'b0; #1;
      check("R10 no read strobe", bus_rdata, 0);
   endtask

   initial begin
      #200000000;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_period();
      t_reload_write();
      t_restart();
      t_halt();
      t_chain();
      t_unmapped();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule